// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the architectural state update that a 64-bit processor with windowed registers makes when it accepts a trap. The core presents a trap request with a 9-bit trap type and its current state: program counter, next program counter, condition codes, address space identifier, processor state word, current window pointer, spill headroom (the count of windows that may still be saved) and trap level, plus the trap base address.

In the clock edge that accepts the request, the block pushes a saved-state record into a small trap-stack register file. The record holds a packed state word, PC, NPC and trap type, and its slot is picked by the new trap level. The same edge registers the new trap level, the processor state word with its selected global register set, the adjusted window pointer and the vectored PC/NPC. A request made when the level is already at its ceiling saves nothing. It is reported as an error-state condition. A combinational read port returns any trap-stack slot by level.

Top module: `trap_entry_seq`

## Requirements
- R1: When `tl_in >= MAX_TL` (default 5) a request changes no output register and writes no trap-stack slot. `err_state_o` is 1 together with the done pulse.
- R2: An accepted request sets `tl_o` to `tl_in + 1`. When `tl_in >= MAX_TL-1` it also sets the reduced-state bit (bit 5) of `pstate_o`.
- R3: The saved state word is 40 bits wide. Bits 39:32 hold `ccr_in`, bits 31:24 hold `asi_in`, bits 23:20 are zero, bits 19:8 hold `pstate_in & 12'hF3F`, and the low `CWP_W` bits hold `cwp_in`. All other bits are zero.
- R4: The slot indexed by the new level masked with `2**TL_W-1` stores the state word, `pc_in`, `npc_in` and `req_tt`. `rd_lvl` reads a slot combinationally, and all slots read zero after reset.
- R5: After an accepted trap, `pstate_o` is exactly bit 4 (FPU enable) | bit 2 (privileged) | one global-set bit | the reduced-state bit when R2 calls for it. The global-set bits are bit 0 (alternate), bit 10 (MMU) and bit 11 (interrupt).
- R6: Trap type 0x060 selects the interrupt set. Types 0x008, 0x030 and 0x064 through 0x06F select the MMU set. Every other type selects the alternate set.
- R7: `cwp_o` is derived modulo `NWIN` (default 8) by the first rule that matches the trap type. Type 0x024 gives `cwp-1`. A type with `(tt & 0x1C0) == 0x080` gives `cwp-cansave-2`. A type with `(tt & 0x1C0) == 0x0C0` gives `cwp+1`. Any other type leaves the pointer unchanged.
- R8: `pc_o` takes `tba_in` bits 63:15, bit 14 = (new level > 1), bits 13:5 = `req_tt`, and bits 4:0 = 0. `npc_o = pc_o + 4`.
- R9: `done_o` pulses for exactly one cycle, one cycle after each request, and the R1–R8 results appear in that same cycle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request, one cycle |
| req_tt | input | 9 | Trap type |
| pc_in | input | PC_W | Current PC |
| npc_in | input | PC_W | Current next PC |
| ccr_in | input | 8 | Condition codes |
| asi_in | input | 8 | Address space identifier |
| pstate_in | input | 12 | Current processor state word |
| cwp_in | input | CWP_W | Current window pointer |
| cansave_in | input | CWP_W | Windows still saveable |
| tl_in | input | TL_W | Current trap level |
| tba_in | input | PC_W | Trap base address |
| done_o | output | 1 | One-cycle completion pulse |
| err_state_o | output | 1 | Request arrived at maximum level |
| tl_o | output | TL_W | New trap level |
| pstate_o | output | 12 | New processor state word |
| cwp_o | output | CWP_W | New window pointer |
| pc_o | output | PC_W | Trap vector |
| npc_o | output | PC_W | Trap vector plus 4 |
| rd_lvl | input | TL_W | Trap-stack read index |
| rd_tstate | output | 40 | Read slot: packed state word |
| rd_tpc | output | PC_W | Read slot: saved PC |
| rd_tnpc | output | PC_W | Read slot: saved NPC |
| rd_tt | output | 9 | Read slot: saved trap type |

## Verification
Every registered result is due exactly one clock edge after the request: the new level, state word, window pointer, vector, `done_o` and `err_state_o`. The trap-stack slot is written at that same edge and is visible on the combinational read port straight after it. The bench drives each request on a falling edge and samples all results on the following falling edge, with `rd_lvl` already pointing at the expected slot. It then samples once more a cycle later to confirm that `done_o` has dropped. The checks for the error case compare outputs captured before the request with those after it.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int TT_W  = 9;
  localparam int PS_W  = 12;
  localparam int TS_W  = 40;

  // processor state word bit positions
  localparam int PS_ALT_G  = 0;
  localparam int PS_PRIV   = 2;
  localparam int PS_FPEN   = 4;
  localparam int PS_RED    = 5;
  localparam int PS_MMU_G  = 10;
  localparam int PS_INT_G  = 11;

  localparam logic [PS_W-1:0] PS_KEEP_MASK = 12'hF3F;

  // trap type codes
  localparam logic [TT_W-1:0] TT_INSN_FAULT = 9'h008;
  localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
  localparam logic [TT_W-1:0] TT_DATA_FAULT = 9'h030;
  localparam logic [TT_W-1:0] TT_INT_VEC    = 9'h060;
  localparam logic [TT_W-1:0] TT_MMU_LO     = 9'h064;
  localparam logic [TT_W-1:0] TT_MMU_HI     = 9'h06F;
  localparam logic [TT_W-1:0] TT_GROUP_MASK = 9'h1C0;
  localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
  localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;

  typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
  typedef enum logic [1:0] {WADJ_NONE, WADJ_DEC, WADJ_SPILL, WADJ_INC} wadj_e;

  function automatic gsel_e pick_global(input logic [TT_W-1:0] tt);
    if (tt == TT_INT_VEC)
      return GSEL_INT;
    else if (tt == TT_INSN_FAULT || tt == TT_DATA_FAULT ||
             (tt >= TT_MMU_LO && tt <= TT_MMU_HI))
      return GSEL_MMU;
    else
      return GSEL_ALT;
  endfunction

  function automatic wadj_e pick_wadj(input logic [TT_W-1:0] tt);
    if (tt == TT_CLEAN_WIN)
      return WADJ_DEC;
    else if ((tt & TT_GROUP_MASK) == TT_SPILL_BASE)
      return WADJ_SPILL;
    else if ((tt & TT_GROUP_MASK) == TT_FILL_BASE)
      return WADJ_INC;
    else
      return WADJ_NONE;
  endfunction

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
  parameter int MAX_TL = 5,
  parameter int TL_W   = $clog2(MAX_TL + 1)
) (
  input  logic [TL_W-1:0] tl_cur,
  output logic [TL_W-1:0] tl_next,
  output logic            red_set,
  output logic            err_state
);
  localparam logic [TL_W-1:0] TL_CEIL = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_NEAR = TL_W'(MAX_TL - 1);

  always_comb begin
    err_state = (tl_cur >= TL_CEIL);
    red_set   = (tl_cur >= TL_NEAR) && !err_state;
    tl_next   = tl_cur + TL_W'(1);
  end
endmodule

// File: rtl/trap_cwp_adj.sv
module trap_cwp_adj
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic [TT_W-1:0]  tt,
  input  logic [CWP_W-1:0] cwp,
  input  logic [CWP_W-1:0] cansave,
  output logic [CWP_W-1:0] cwp_next
);
  localparam int SUM_W = $clog2(3 * NWIN + 1);
  localparam logic [SUM_W-1:0] N1 = SUM_W'(NWIN);
  localparam logic [SUM_W-1:0] N2 = SUM_W'(2 * NWIN);

  wadj_e            kind;
  logic [SUM_W-1:0] raw;
  logic [SUM_W-1:0] red1;
  logic [SUM_W-1:0] red2;

  always_comb begin
    kind = pick_wadj(tt);
    unique case (kind)
      WADJ_DEC:   raw = SUM_W'(cwp) + N1 - SUM_W'(1);
      WADJ_SPILL: raw = SUM_W'(cwp) + N2 - SUM_W'(cansave) - SUM_W'(2);
      WADJ_INC:   raw = SUM_W'(cwp) + SUM_W'(1);
      default:    raw = SUM_W'(cwp);
    endcase
    red1     = (raw >= N2) ? raw - N2 : raw;
    red2     = (red1 >= N1) ? red1 - N1 : red1;
    cwp_next = red2[CWP_W-1:0];
  end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_entry_pkg::*;
#(
  parameter int PC_W = 64,
  parameter int TL_W = 3
) (
  input  logic [PC_W-1:0] tba,
  input  logic [TT_W-1:0] tt,
  input  logic [TL_W-1:0] tl_next,
  output logic [PC_W-1:0] vec_pc,
  output logic [PC_W-1:0] vec_npc
);
  localparam logic [PC_W-1:0] LOW_MASK = PC_W'(15'h7FFF);

  logic nested;

  always_comb begin
    nested  = (tl_next > TL_W'(1));
    vec_pc  = (tba & ~LOW_MASK)
            | (PC_W'(nested) << 14)
            | (PC_W'(tt) << 5);
    vec_npc = vec_pc + PC_W'(4);
  end
endmodule

// File: rtl/trap_stack_rf.sv
module trap_stack_rf
  import trap_entry_pkg::*;
#(
  parameter int TL_W = 3,
  parameter int PC_W = 64,
  parameter int DEPTH = 2 ** TL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TL_W-1:0] wr_idx,
  input  logic [TS_W-1:0] wr_tstate,
  input  logic [PC_W-1:0] wr_tpc,
  input  logic [PC_W-1:0] wr_tnpc,
  input  logic [TT_W-1:0] wr_tt,
  input  logic [TL_W-1:0] rd_idx,
  output logic [TS_W-1:0] rd_tstate,
  output logic [PC_W-1:0] rd_tpc,
  output logic [PC_W-1:0] rd_tnpc,
  output logic [TT_W-1:0] rd_tt
);
  logic [TS_W-1:0] ts_q  [DEPTH];
  logic [PC_W-1:0] pc_q  [DEPTH];
  logic [PC_W-1:0] npc_q [DEPTH];
  logic [TT_W-1:0] tt_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == TL_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ts_q[e]  <= '0;
        pc_q[e]  <= '0;
        npc_q[e] <= '0;
        tt_q[e]  <= '0;
      end else if (slot_en) begin
        ts_q[e]  <= wr_tstate;
        pc_q[e]  <= wr_tpc;
        npc_q[e] <= wr_tnpc;
        tt_q[e]  <= wr_tt;
      end
    end
  end

  always_comb begin
    rd_tstate = ts_q[rd_idx];
    rd_tpc    = pc_q[rd_idx];
    rd_tnpc   = npc_q[rd_idx];
    rd_tt     = tt_q[rd_idx];
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int NWIN   = 8,
  parameter int PC_W   = 64,
  parameter int TL_W   = $clog2(MAX_TL + 1),
  parameter int CWP_W  = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TT_W-1:0]  req_tt,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PC_W-1:0]  npc_in,
  input  logic [7:0]       ccr_in,
  input  logic [7:0]       asi_in,
  input  logic [PS_W-1:0]  pstate_in,
  input  logic [CWP_W-1:0] cwp_in,
  input  logic [CWP_W-1:0] cansave_in,
  input  logic [TL_W-1:0]  tl_in,
  input  logic [PC_W-1:0]  tba_in,
  output logic             done_o,
  output logic             err_state_o,
  output logic [TL_W-1:0]  tl_o,
  output logic [PS_W-1:0]  pstate_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  npc_o,
  input  logic [TL_W-1:0]  rd_lvl,
  output logic [TS_W-1:0]  rd_tstate,
  output logic [PC_W-1:0]  rd_tpc,
  output logic [PC_W-1:0]  rd_tnpc,
  output logic [TT_W-1:0]  rd_tt
);
  localparam logic [TL_W-1:0] SLOT_MASK = {TL_W{1'b1}};

  logic [TL_W-1:0]  tl_nx;
  logic             red_nx;
  logic             err_nx;
  logic [CWP_W-1:0] cwp_nx;
  logic [PC_W-1:0]  pc_nx;
  logic [PC_W-1:0]  npc_nx;
  logic [PS_W-1:0]  ps_nx;
  logic [TS_W-1:0]  tstate_nx;
  logic             accept;
  gsel_e            gsel;

  trap_level_ctl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_level (
    .tl_cur   (tl_in),
    .tl_next  (tl_nx),
    .red_set  (red_nx),
    .err_state(err_nx)
  );

  trap_cwp_adj #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
    .tt      (req_tt),
    .cwp     (cwp_in),
    .cansave (cansave_in),
    .cwp_next(cwp_nx)
  );

  trap_vec_gen #(.PC_W(PC_W), .TL_W(TL_W)) u_vec (
    .tba    (tba_in),
    .tt     (req_tt),
    .tl_next(tl_nx),
    .vec_pc (pc_nx),
    .vec_npc(npc_nx)
  );

  // next-state: processor state word and saved record
  always_comb begin
    accept = req_valid && !err_nx;
    gsel   = pick_global(req_tt);
    ps_nx  = '0;
    ps_nx[PS_FPEN] = 1'b1;
    ps_nx[PS_PRIV] = 1'b1;
    ps_nx[PS_RED]  = red_nx;
    unique case (gsel)
      GSEL_INT: ps_nx[PS_INT_G] = 1'b1;
      GSEL_MMU: ps_nx[PS_MMU_G] = 1'b1;
      default:  ps_nx[PS_ALT_G] = 1'b1;
    endcase
    tstate_nx = '0;
    tstate_nx[39:32]     = ccr_in;
    tstate_nx[31:24]     = asi_in;
    tstate_nx[19:8]      = pstate_in & PS_KEEP_MASK;
    tstate_nx[CWP_W-1:0] = cwp_in;
  end

  trap_stack_rf #(.TL_W(TL_W), .PC_W(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_idx   (tl_nx & SLOT_MASK),
    .wr_tstate(tstate_nx),
    .wr_tpc   (pc_in),
    .wr_tnpc  (npc_in),
    .wr_tt    (req_tt),
    .rd_idx   (rd_lvl),
    .rd_tstate(rd_tstate),
    .rd_tpc   (rd_tpc),
    .rd_tnpc  (rd_tnpc),
    .rd_tt    (rd_tt)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      err_state_o <= 1'b0;
    end else begin
      done_o      <= req_valid;
      err_state_o <= req_valid && err_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_o     <= '0;
      pstate_o <= '0;
      cwp_o    <= '0;
      pc_o     <= '0;
      npc_o    <= '0;
    end else if (accept) begin
      tl_o     <= tl_nx;
      pstate_o <= ps_nx;
      cwp_o    <= cwp_nx;
      pc_o     <= pc_nx;
      npc_o    <= npc_nx;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  parameter int TL_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [TL_W-1:0] tl_in,
  input logic            done_o,
  input logic            err_state_o,
  input logic [TL_W-1:0] tl_o,
  input logic [PS_W-1:0] pstate_o,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] npc_o
);
  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  assert_done_tracks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (done_o == $past(req_valid)));

  assert_err_only_at_ceiling_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && err_state_o) |-> (done_o && ($past(tl_in) >= TL_W'(MAX_TL))));

  assert_hold_on_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && err_state_o) |-> ($stable(pc_o) && $stable(tl_o)));

  assert_level_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && done_o && !err_state_o) |-> (tl_o == $past(tl_in) + TL_W'(1)));

  assert_priv_fpen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_state_o) |-> (pstate_o[PS_PRIV] && pstate_o[PS_FPEN]));

  assert_single_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_state_o) |->
      ($countones({pstate_o[PS_ALT_G], pstate_o[PS_MMU_G], pstate_o[PS_INT_G]}) == 1));

  assert_vec_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[4:0] == 5'd0);

  assert_npc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_state_o) |-> (npc_o == pc_o + PC_W'(4)));
endmodule

bind trap_entry_seq trap_entry_chk #(.MAX_TL(MAX_TL), .PC_W(PC_W), .TL_W(TL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .tl_in      (tl_in),
  .done_o     (done_o),
  .err_state_o(err_state_o),
  .tl_o       (tl_o),
  .pstate_o   (pstate_o),
  .pc_o       (pc_o),
  .npc_o      (npc_o)
);

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [8:0]  req_tt;
  logic [63:0] pc_in, npc_in, tba_in;
  logic [7:0]  ccr_in, asi_in;
  logic [11:0] pstate_in;
  logic [2:0]  cwp_in, cansave_in, tl_in, rd_lvl;
  logic        done_o, err_state_o;
  logic [2:0]  tl_o, cwp_o;
  logic [11:0] pstate_o;
  logic [63:0] pc_o, npc_o, rd_tpc, rd_tnpc;
  logic [39:0] rd_tstate;
  logic [8:0]  rd_tt;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  trap_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tt(req_tt),
    .pc_in(pc_in), .npc_in(npc_in), .ccr_in(ccr_in), .asi_in(asi_in),
    .pstate_in(pstate_in), .cwp_in(cwp_in), .cansave_in(cansave_in),
    .tl_in(tl_in), .tba_in(tba_in), .done_o(done_o), .err_state_o(err_state_o),
    .tl_o(tl_o), .pstate_o(pstate_o), .cwp_o(cwp_o), .pc_o(pc_o), .npc_o(npc_o),
    .rd_lvl(rd_lvl), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc),
    .rd_tt(rd_tt)
  );

  // {tt, tl, cwp, cansave, exp_tl, exp_cwp, exp_pstate}
  localparam logic [35:0] VECS [NV] = '{
    {9'h060, 3'd0, 3'd3, 3'd2, 3'd1, 3'd3, 12'h814},  // interrupt set
    {9'h008, 3'd1, 3'd0, 3'd0, 3'd2, 3'd0, 12'h414},  // insn fault, MMU
    {9'h066, 3'd2, 3'd5, 3'd1, 3'd3, 3'd5, 12'h414},  // miss range
    {9'h06F, 3'd0, 3'd2, 3'd0, 3'd1, 3'd2, 12'h414},  // top of MMU range
    {9'h024, 3'd0, 3'd0, 3'd3, 3'd1, 3'd7, 12'h015},  // clean window wraps
    {9'h080, 3'd1, 3'd1, 3'd6, 3'd2, 3'd1, 12'h015},  // spill, 1-6-2 mod 8
    {9'h0A4, 3'd0, 3'd4, 3'd0, 3'd1, 3'd2, 12'h015},  // spill group
    {9'h0C0, 3'd2, 3'd7, 3'd0, 3'd3, 3'd0, 12'h015},  // fill wraps
    {9'h0FC, 3'd3, 3'd3, 3'd5, 3'd4, 3'd4, 12'h015},  // fill group
    {9'h005, 3'd4, 3'd6, 3'd0, 3'd5, 3'd6, 12'h035},  // reduced state
    {9'h100, 3'd0, 3'd2, 3'd4, 3'd1, 3'd2, 12'h015},  // neither group
    {9'h030, 3'd4, 3'd1, 3'd2, 3'd5, 3'd1, 12'h434}   // data fault + reduced
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic fire(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] cwp,
                      input logic [2:0] cs, input logic [2:0] rdl);
    @(negedge clk);
    req_tt = tt; tl_in = tl; cwp_in = cwp; cansave_in = cs; rd_lvl = rdl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] exp_vec(input logic [63:0] tba, input logic [8:0] tt,
                                          input logic [2:0] ntl);
    return (tba & ~64'h7FFF) | ((ntl > 3'd1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] pc_keep;
    logic [2:0]  tl_keep;
    logic [11:0] ps_keep;
    rst_n = 1'b0; req_valid = 1'b0; req_tt = '0; pc_in = '0; npc_in = '0;
    tba_in = '0; ccr_in = '0; asi_in = '0; pstate_in = '0; cwp_in = '0;
    cansave_in = '0; tl_in = '0; rd_lvl = 3'd1;
    repeat (3) @(negedge clk);
    // R9 / R4: reset state
    chk("R9 reset done", 64'(done_o), 0);
    chk("R9 reset tl", 64'(tl_o), 0);
    chk("R9 reset pc", pc_o, 0);
    chk("R4 reset slot", 64'(rd_tt), 0);
    rst_n = 1'b1;

    tba_in = 64'hFFFF_0000_1234_5ABC; ccr_in = 8'hC5; asi_in = 8'h82;
    pstate_in = 12'hAC9;
    for (int i = 0; i < NV; i++) begin
      logic [8:0] tt;
      logic [2:0] tl, cw, cs, etl, ecw;
      logic [11:0] eps;
      {tt, tl, cw, cs, etl, ecw, eps} = VECS[i];
      pc_in  = 64'h0000_4000_0000_0100 + 64'(i * 16);
      npc_in = pc_in + 64'd4;
      fire(tt, tl, cw, cs, etl);
      chk("R9 done", 64'(done_o), 1);
      chk("R1 no err", 64'(err_state_o), 0);
      chk("R2 level", 64'(tl_o), 64'(etl));
      chk("R5 R6 pstate", 64'(pstate_o), 64'(eps));
      chk("R7 cwp", 64'(cwp_o), 64'(ecw));
      chk("R8 pc", pc_o, exp_vec(tba_in, tt, etl));
      chk("R8 npc", npc_o, exp_vec(tba_in, tt, etl) + 64'd4);
      chk("R3 tstate", 64'(rd_tstate),
          64'({ccr_in, asi_in, 4'h0, pstate_in & 12'hF3F, 5'h0, cw}));
      chk("R4 tpc", rd_tpc, pc_in);
      chk("R4 tnpc", rd_tnpc, npc_in);
      chk("R4 tt", 64'(rd_tt), 64'(tt));
      @(negedge clk);
      chk("R9 done drops", 64'(done_o), 0);
    end

    // R1: requests at and above the ceiling
    for (int k = 5; k < 8; k++) begin
      pc_keep = pc_o; tl_keep = tl_o; ps_keep = pstate_o;
      fire(9'h041, 3'(k), 3'd2, 3'd1, 3'((k + 1) & 7));
      chk("R1 done", 64'(done_o), 1);
      chk("R1 err", 64'(err_state_o), 1);
      chk("R1 pc held", pc_o, pc_keep);
      chk("R1 tl held", 64'(tl_o), 64'(tl_keep));
      chk("R1 pstate held", 64'(pstate_o), 64'(ps_keep));
      if (k != 7) chk("R1 slot untouched", 64'(rd_tt), 0);
      else        chk("R1 slot untouched", rd_tpc, 0);
      @(negedge clk);
      chk("R1 err drops", 64'(err_state_o), 0);
    end

    // R4: earlier slot survives later traps
    rd_lvl = 3'd4;
    @(negedge clk);
    chk("R4 slot 4 kept", 64'(rd_tt), 64'h0FC);
    finish_run();
  end
endmodule